// File: doc/BRIEF.md
# Profiled IIR Servo Channel

This block is one channel of an amplitude servo loop. Once per servo cycle it takes a fresh set of signed 16-bit converter samples and runs a first-order IIR update. The coefficients, the setpoint offset, the converter channel and a hold-off count all come from whichever of 32 profiles the channel control word selects. The result is an 18-bit unsigned amplitude scale factor. It is saturated and then written back to the state slot of that profile. The control word also drives the RF switch enable.

Software loads profile words and may overwrite a profile's stored output through a configuration port. A combinational read port returns any profile word or any stored output. Any change to the control word freezes filter updates for the number of servo cycles held in the new profile's hold-off field. When the global enable is removed, a pass that is already in flight runs to completion, and `done` then reports that the channel is idle.

Top module: `servo_channel`

## Requirements
- R1: After reset, `rf_sw`, `y_strobe` and `y_out` are 0. Every profile word and every stored output reads 0. `done` is 1 while `servo_en` is low.
- R2: Control word encoding: bit 0 is the RF switch enable, bit 1 is the IIR update enable and bits 6:2 are the active profile. `rf_sw` takes bit 0 on the clock edge that accepts `ctrl_we`.
- R3: Each profile has five 18-bit words, written with `cfg_we` at (`cfg_profile`, `cfg_word`): word 0 B0, word 1 B1, word 2 A1, word 3 selector, word 4 offset. Word 3 holds the converter channel in bits 2:0 and the hold-off count in bits 17:8. With `rd_state` low, `rd_data` returns the word at (`rd_profile`, `rd_word`). Word indices 5 to 7 read 0 and ignore writes.
- R4: When `cycle_tick` is high with `servo_en` high at an idle clock edge, all eight samples are captured and each channel's previous X0 becomes its X1. The filter result is issued at the next edge, with `y_out` valid and `y_strobe` high for one cycle. `y_out` changes only when `y_strobe` is high.
- R5: The result is (A1·Y1 + B0·(X0+off) + B1·(X1+off)) >>> 17. Y1 is the active profile's stored output. X0 and X1 belong to the profile's selected channel.
- R6: A shifted result below 0 becomes 0, and one above 262143 becomes 262143.
- R7: The converter channel is taken from bits 2:0 of the active profile's word 3. Samples sit at `adc_samples[16*c +: 16]`.
- R8: When IIR enable (control bit 1) is 0, a pass issues no strobe and leaves the stored output and `y_out` unchanged.
- R9: A control write that changes the control word loads the hold-off count of the new profile. Each later pass with a non-zero count decrements it and issues no update. A rewrite with an identical value does not reload the count.
- R10: `y_we` writes `cfg_data` into the stored output of `cfg_profile`. With `rd_state` high, `rd_data` returns the stored output of `rd_profile`.
- R11: After `servo_en` falls, an in-flight pass still completes. `done` is high only when `servo_en` is low and no pass is in flight.
- R12: `cycle_tick` while `servo_en` is low captures no samples and issues no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| servo_en | input | 1 | Global servo enable |
| cycle_tick | input | 1 | Start-of-servo-cycle strobe |
| ctrl_we | input | 1 | Control word write |
| ctrl_word | input | 7 | {profile[4:0], IIR enable, RF enable} |
| cfg_we | input | 1 | Profile word write |
| y_we | input | 1 | Stored-output write |
| cfg_profile | input | 5 | Profile addressed by writes |
| cfg_word | input | 3 | Word addressed by profile writes |
| cfg_data | input | 18 | Write data |
| adc_samples | input | 128 | Eight signed 16-bit samples |
| rd_state | input | 1 | Read select: 1 stored output, 0 profile word |
| rd_profile | input | 5 | Read profile |
| rd_word | input | 3 | Read word |
| rd_data | output | 18 | Read data |
| rf_sw | output | 1 | RF switch enable |
| y_out | output | 18 | Last updated output |
| y_strobe | output | 1 | One-cycle update pulse |
| done | output | 1 | Disabled and idle |

## Verification
The hardest situation to reach is a pass that is already in flight when `servo_en` drops. The bench raises `cycle_tick`, then clears the enable on the very next falling edge. It confirms that `done` stays low in that cycle and that the strobe and result still arrive. It then ticks with the enable low and shows, through a B1-weighted pass, that the X history was not advanced. The hold-off window is brought about by configuring a non-zero count before switching profiles, and the identical-rewrite case is checked right after.

// File: rtl/servo_pkg.sv
package servo_pkg;
  localparam int NPROF   = 32;
  localparam int NADC    = 8;
  localparam int SMP_W   = 16;
  localparam int CF_W    = 18;
  localparam int Y_W     = 18;
  localparam int HOLD_W  = 10;
  localparam int HOLD_LSB = 8;
  localparam int SHIFT   = 17;
  localparam int NWORD   = 5;
  localparam int WORD_AW = 3;
  localparam int PROF_AW = $clog2(NPROF);
  localparam int ADC_AW  = $clog2(NADC);
  localparam int CTRL_W  = 2 + PROF_AW;

  localparam int W_B0  = 0;
  localparam int W_B1  = 1;
  localparam int W_A1  = 2;
  localparam int W_SEL = 3;
  localparam int W_OFF = 4;

  typedef enum logic {ST_IDLE, ST_CALC} seq_t;
endpackage

// File: rtl/servo_profile_store.sv
module servo_profile_store
  import servo_pkg::*;
#(
  parameter int NP = NPROF,
  parameter int NW = NWORD,
  parameter int DW = CF_W,
  parameter int AAW = ADC_AW,
  parameter int HW = HOLD_W,
  localparam int PAW = $clog2(NP)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [PAW-1:0] wr_prof,
  input  logic [WORD_AW-1:0] wr_word,
  input  logic [DW-1:0]  wr_data,
  input  logic [PAW-1:0] rd_prof,
  input  logic [WORD_AW-1:0] rd_word,
  output logic [DW-1:0]  rd_data,
  input  logic [PAW-1:0] act_prof,
  output logic [DW-1:0]  act_b0,
  output logic [DW-1:0]  act_b1,
  output logic [DW-1:0]  act_a1,
  output logic [DW-1:0]  act_off,
  output logic [AAW-1:0] act_adc,
  input  logic [PAW-1:0] lk_prof,
  output logic [HW-1:0]  lk_hold
);
  logic [DW-1:0] mem_q [NP][NW];

  for (genvar p = 0; p < NP; p++) begin : g_prof
    for (genvar w = 0; w < NW; w++) begin : g_word
      logic hit;
      assign hit = wr_en && (wr_prof == PAW'(p)) && (wr_word == WORD_AW'(w));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   mem_q[p][w] <= '0;
        else if (hit) mem_q[p][w] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_word) < NW) rd_data = mem_q[rd_prof][rd_word];
  end

  logic [DW-1:0] sel_word;
  logic [DW-1:0] lk_word;
  always_comb begin
    act_b0   = mem_q[act_prof][W_B0];
    act_b1   = mem_q[act_prof][W_B1];
    act_a1   = mem_q[act_prof][W_A1];
    act_off  = mem_q[act_prof][W_OFF];
    sel_word = mem_q[act_prof][W_SEL];
    act_adc  = sel_word[AAW-1:0];
    lk_word  = mem_q[lk_prof][W_SEL];
    lk_hold  = lk_word[HOLD_LSB +: HW];
  end
endmodule

// File: rtl/servo_iir_math.sv
module servo_iir_math
  import servo_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int CW = CF_W,
  parameter int YW = Y_W,
  parameter int SH = SHIFT
) (
  input  logic signed [CW-1:0] a1,
  input  logic signed [CW-1:0] b0,
  input  logic signed [CW-1:0] b1,
  input  logic signed [CW-1:0] off,
  input  logic signed [SW-1:0] x0,
  input  logic signed [SW-1:0] x1,
  input  logic        [YW-1:0] y1,
  output logic        [YW-1:0] y0
);
  localparam int XW = ((SW > CW) ? SW : CW) + 1;
  localparam int MW = (XW > YW + 1) ? XW : YW + 1;
  localparam int AW = CW + MW + 2;
  localparam logic signed [AW-1:0] YMAX = {{(AW-YW){1'b0}}, {YW{1'b1}}};

  logic signed [XW-1:0]   x0e, x1e;
  logic signed [YW:0]     y1e;
  logic signed [AW-1:0]   acc, sh;

  always_comb begin
    x0e = XW'(x0) + XW'(off);
    x1e = XW'(x1) + XW'(off);
    y1e = $signed({1'b0, y1});
    acc = AW'(a1) * AW'(y1e) + AW'(b0) * AW'(x0e) + AW'(b1) * AW'(x1e);
    sh  = acc >>> SH;
    if (sh < 0)         y0 = '0;
    else if (sh > YMAX) y0 = '1;
    else                y0 = sh[YW-1:0];
  end
endmodule

// File: rtl/servo_holdoff.sv
module servo_holdoff
  import servo_pkg::*;
#(
  parameter int HW = HOLD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [HW-1:0] load_val,
  input  logic          step,
  output logic [HW-1:0] cnt,
  output logic          zero
);
  logic [HW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                     cnt_d = load_val;
    else if (step && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);
endmodule

// File: rtl/servo_channel.sv
module servo_channel
  import servo_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   servo_en,
  input  logic                   cycle_tick,
  input  logic                   ctrl_we,
  input  logic [CTRL_W-1:0]      ctrl_word,
  input  logic                   cfg_we,
  input  logic                   y_we,
  input  logic [PROF_AW-1:0]     cfg_profile,
  input  logic [WORD_AW-1:0]     cfg_word,
  input  logic [CF_W-1:0]        cfg_data,
  input  logic [NADC*SMP_W-1:0]  adc_samples,
  input  logic                   rd_state,
  input  logic [PROF_AW-1:0]     rd_profile,
  input  logic [WORD_AW-1:0]     rd_word,
  output logic [CF_W-1:0]        rd_data,
  output logic                   rf_sw,
  output logic [Y_W-1:0]         y_out,
  output logic                   y_strobe,
  output logic                   done
);
  // control word register
  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_chg;
  logic              iir_en;
  logic [PROF_AW-1:0] act_prof;

  assign ctrl_chg = ctrl_we && (ctrl_word != ctrl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_word;
  end

  assign rf_sw    = ctrl_q[0];
  assign iir_en   = ctrl_q[1];
  assign act_prof = ctrl_q[CTRL_W-1:2];

  // profile store
  logic [CF_W-1:0]   st_rd;
  logic [CF_W-1:0]   p_b0, p_b1, p_a1, p_off;
  logic [ADC_AW-1:0] p_adc;
  logic [HOLD_W-1:0] new_hold;

  servo_profile_store #(
    .NP(NPROF), .NW(NWORD), .DW(CF_W), .AAW(ADC_AW), .HW(HOLD_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_prof(cfg_profile), .wr_word(cfg_word), .wr_data(cfg_data),
    .rd_prof(rd_profile), .rd_word(rd_word), .rd_data(st_rd),
    .act_prof(act_prof),
    .act_b0(p_b0), .act_b1(p_b1), .act_a1(p_a1), .act_off(p_off), .act_adc(p_adc),
    .lk_prof(ctrl_word[CTRL_W-1:2]), .lk_hold(new_hold)
  );

  // pass sequencer
  seq_t state_q, state_d;
  logic start;
  logic in_calc;

  assign start   = (state_q == ST_IDLE) && servo_en && cycle_tick;
  assign in_calc = (state_q == ST_CALC);

  always_comb begin
    state_d = state_q;
    if (start)        state_d = ST_CALC;
    else if (in_calc) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign done = (state_q == ST_IDLE) && !servo_en;

  // per-channel sample history
  logic [SMP_W-1:0] x0_q [NADC];
  logic [SMP_W-1:0] x1_q [NADC];

  for (genvar c = 0; c < NADC; c++) begin : g_adc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x0_q[c] <= '0;
        x1_q[c] <= '0;
      end else if (start) begin
        x1_q[c] <= x0_q[c];
        x0_q[c] <= adc_samples[c*SMP_W +: SMP_W];
      end
    end
  end

  // hold-off
  logic [HOLD_W-1:0] hold_cnt;
  logic              hold_zero;

  servo_holdoff #(.HW(HOLD_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load(ctrl_chg), .load_val(new_hold), .step(in_calc),
    .cnt(hold_cnt), .zero(hold_zero)
  );

  // filter
  logic [Y_W-1:0] y_q [NPROF];
  logic [Y_W-1:0] y_prev, y_new;
  logic           upd;

  assign y_prev = y_q[act_prof];
  assign upd    = in_calc && iir_en && hold_zero;

  servo_iir_math #(.SW(SMP_W), .CW(CF_W), .YW(Y_W), .SH(SHIFT)) u_math (
    .a1($signed(p_a1)), .b0($signed(p_b0)), .b1($signed(p_b1)), .off($signed(p_off)),
    .x0($signed(x0_q[p_adc])), .x1($signed(x1_q[p_adc])),
    .y1(y_prev), .y0(y_new)
  );

  for (genvar p = 0; p < NPROF; p++) begin : g_state
    logic svc_hit, host_hit;
    assign svc_hit  = upd && (act_prof == PROF_AW'(p));
    assign host_hit = y_we && (cfg_profile == PROF_AW'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        y_q[p] <= '0;
      else if (svc_hit)  y_q[p] <= y_new;
      else if (host_hit) y_q[p] <= cfg_data;
    end
  end

  logic [Y_W-1:0] y_out_q;
  logic           y_stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_out_q <= '0;
      y_stb_q <= 1'b0;
    end else begin
      y_stb_q <= upd;
      if (upd) y_out_q <= y_new;
    end
  end

  assign y_out    = y_out_q;
  assign y_strobe = y_stb_q;
  assign rd_data  = rd_state ? y_q[rd_profile] : st_rd;
endmodule

// File: rtl/servo_channel_chk.sv
module servo_channel_chk
  import servo_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              servo_en,
  input logic              ctrl_we,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              rf_sw,
  input logic [Y_W-1:0]    y_out,
  input logic              y_strobe,
  input logic              done,
  input logic [HOLD_W-1:0] hold_cnt,
  input logic              iir_en
);
  // R2
  rf_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> rf_sw == $past(ctrl_word[0]));

  // R9
  hold_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_strobe |-> $past(hold_cnt) == '0);

  // R8
  iir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_strobe |-> $past(iir_en));

  // R11
  done_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !servo_en);

  // R11
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!servo_en && $past(!servo_en)) |-> done);

  // R4
  y_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(y_out) |-> y_strobe);
endmodule

bind servo_channel servo_channel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .servo_en(servo_en), .ctrl_we(ctrl_we),
  .ctrl_word(ctrl_word), .rf_sw(rf_sw), .y_out(y_out), .y_strobe(y_strobe),
  .done(done), .hold_cnt(hold_cnt), .iir_en(iir_en)
);

// File: tb/servo_channel_bench.sv
`timescale 1ns/1ps
module servo_channel_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        servo_en, cycle_tick, ctrl_we, cfg_we, y_we, rd_state;
  logic [6:0]  ctrl_word;
  logic [4:0]  cfg_profile, rd_profile;
  logic [2:0]  cfg_word, rd_word;
  logic [17:0] cfg_data, rd_data, y_out;
  logic [127:0] adc_samples;
  logic        rf_sw, y_strobe, done;

  logic signed [15:0] adc_v [8];
  longint bx0 [8];
  longint bx1 [8];
  longint ym [32];
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < 8; g++) begin : g_adc
    assign adc_samples[g*16 +: 16] = adc_v[g];
  end

  servo_channel u_servo_channel (
    .clk(clk), .rst_n(rst_n), .servo_en(servo_en), .cycle_tick(cycle_tick),
    .ctrl_we(ctrl_we), .ctrl_word(ctrl_word), .cfg_we(cfg_we), .y_we(y_we),
    .cfg_profile(cfg_profile), .cfg_word(cfg_word), .cfg_data(cfg_data),
    .adc_samples(adc_samples), .rd_state(rd_state), .rd_profile(rd_profile),
    .rd_word(rd_word), .rd_data(rd_data), .rf_sw(rf_sw), .y_out(y_out),
    .y_strobe(y_strobe), .done(done)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_y(longint a1, longint b0, longint b1, longint off,
                                   longint x0, longint x1, longint y1);
    longint v;
    v = a1*y1 + b0*(x0+off) + b1*(x1+off);
    v = v >>> 17;
    if (v < 0) return 0;
    if (v > 262143) return 262143;
    return v;
  endfunction

  task automatic cfg_wr(int p, int w, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_profile = 5'(p); cfg_word = 3'(w); cfg_data = 18'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prof_set(int p, int b0, int b1, int a1, int sel, int off);
    cfg_wr(p, 0, b0); cfg_wr(p, 1, b1); cfg_wr(p, 2, a1);
    cfg_wr(p, 3, sel); cfg_wr(p, 4, off);
  endtask

  task automatic y_wr(int p, int d);
    @(negedge clk);
    y_we = 1'b1; cfg_profile = 5'(p); cfg_data = 18'(d);
    @(negedge clk);
    y_we = 1'b0;
    ym[p] = d;
  endtask

  task automatic ctrl_wr(int prof, bit iir, bit rf);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_word = {5'(prof), iir, rf};
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  function automatic longint rd_word_of(int p, int w);
    rd_state = 1'b0; rd_profile = 5'(p); rd_word = 3'(w);
    return 0;
  endfunction

  task automatic read_prof(int p, int w, output longint v);
    rd_state = 1'b0; rd_profile = 5'(p); rd_word = 3'(w);
    #0.5 v = rd_data;
  endtask

  task automatic read_y(int p, output longint v);
    rd_state = 1'b1; rd_profile = 5'(p); rd_word = 3'd0;
    #0.5 v = rd_data;
  endtask

  // one servo pass; outputs are sampled after the issuing edge
  task automatic servo_pass();
    @(negedge clk);
    cycle_tick = 1'b1;
    if (servo_en) begin
      for (int i = 0; i < 8; i++) begin
        bx1[i] = bx0[i];
        bx0[i] = adc_v[i];
      end
    end
    @(negedge clk);
    cycle_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    longint v;
    chk("R1", "rf_sw", rf_sw, 0);
    chk("R1", "y_strobe", y_strobe, 0);
    chk("R1", "y_out", y_out, 0);
    chk("R1", "done", done, 1);
    read_prof(3, 2, v); chk("R1", "profile word", v, 0);
    read_y(7, v);       chk("R1", "stored output", v, 0);
  endtask

  task automatic t_cfg();
    longint v;
    cfg_wr(5, 0, 12345);
    cfg_wr(5, 4, -7);
    cfg_wr(5, 6, 999);
    read_prof(5, 0, v); chk("R3", "word0 readback", v, 12345);
    read_prof(5, 4, v); chk("R3", "word4 readback", v, 262144 - 7);
    read_prof(5, 6, v); chk("R3", "word6 reads zero", v, 0);
  endtask

  task automatic t_ctrl();
    ctrl_wr(0, 0, 1);
    chk("R2", "rf_sw set", rf_sw, 1);
    ctrl_wr(0, 0, 0);
    chk("R2", "rf_sw clear", rf_sw, 0);
  endtask

  task automatic t_basic();
    longint v;
    prof_set(1, 65536, 0, 0, 0, 0);
    ctrl_wr(1, 1, 1);
    servo_en = 1'b1;
    adc_v[0] = 16'sd1000;
    servo_pass();
    chk("R4", "strobe on pass", y_strobe, 1);
    chk("R5", "basic y_out", y_out, 500);
    ym[1] = 500;
    read_y(1, v); chk("R5", "stored y", v, 500);
    read_y(0, v); chk("R5", "other profile untouched", v, 0);
    @(negedge clk);
    chk("R4", "strobe one cycle", y_strobe, 0);
  endtask

  task automatic t_recur();
    longint e;
    int vals [3] = '{2000, -500, 1500};
    prof_set(1, 65536, 32768, 65536, 0, 100);
    for (int k = 0; k < 3; k++) begin
      adc_v[0] = 16'(vals[k]);
      servo_pass();
      e = exp_y(65536, 65536, 32768, 100, bx0[0], bx1[0], ym[1]);
      ym[1] = e;
      chk("R5", "recursive y_out", y_out, e);
    end
  endtask

  task automatic t_sat();
    prof_set(2, 131071, 0, 131071, 0, 0);
    ctrl_wr(2, 1, 1);
    y_wr(2, 262143);
    adc_v[0] = 16'sd32767;
    servo_pass();
    chk("R6", "saturate high", y_out, 262143);
    prof_set(2, -131072, 0, 0, 0, 0);
    servo_pass();
    chk("R6", "saturate low", y_out, 0);
    chk("R6", "strobe on low", y_strobe, 1);
    ym[2] = 0;
  endtask

  task automatic t_adc();
    longint e;
    prof_set(3, 65536, 0, 0, 5, 0);
    ctrl_wr(3, 1, 1);
    adc_v[5] = 16'sd4000;
    adc_v[0] = -16'sd3000;
    servo_pass();
    e = exp_y(65536, 0, 0, 0, 0, 0, 0) + 2000;
    chk("R7", "channel 5 selected", y_out, e);
    ym[3] = e;
  endtask

  task automatic t_iir_off();
    longint v;
    ctrl_wr(3, 0, 1);
    adc_v[5] = 16'sd100;
    servo_pass();
    chk("R8", "no strobe", y_strobe, 0);
    chk("R8", "y_out held", y_out, 2000);
    read_y(3, v); chk("R8", "stored held", v, 2000);
  endtask

  task automatic t_hold();
    longint e;
    prof_set(4, 65536, 0, 0, (3 << 8), 0);
    ctrl_wr(4, 1, 1);
    adc_v[0] = 16'sd600;
    for (int k = 0; k < 3; k++) begin
      servo_pass();
      chk("R9", "held pass no strobe", y_strobe, 0);
    end
    servo_pass();
    e = exp_y(65536, 0, 0, 0, 0, 0, 0) + 300;
    chk("R9", "update after hold", y_strobe, 1);
    chk("R9", "value after hold", y_out, e);
    ctrl_wr(4, 1, 1);
    adc_v[0] = 16'sd800;
    servo_pass();
    chk("R9", "identical rewrite no reload", y_strobe, 1);
    chk("R9", "value after rewrite", y_out, 400);
    ym[4] = 400;
  endtask

  task automatic t_ywr();
    longint v;
    y_wr(6, 777);
    read_y(6, v); chk("R10", "host y write", v, 777);
  endtask

  task automatic t_disable();
    longint e;
    prof_set(1, 65536, 65536, 0, 0, 0);
    ctrl_wr(1, 1, 1);
    adc_v[0] = 16'sd1000;
    @(negedge clk);
    servo_en = 1'b1; cycle_tick = 1'b1;
    for (int i = 0; i < 8; i++) begin
      bx1[i] = bx0[i];
      bx0[i] = adc_v[i];
    end
    @(negedge clk);
    cycle_tick = 1'b0; servo_en = 1'b0;
    #0.5 chk("R11", "done low in flight", done, 0);
    @(negedge clk);
    e = exp_y(0, 65536, 65536, 0, bx0[0], bx1[0], ym[1]);
    chk("R11", "in-flight strobe", y_strobe, 1);
    chk("R11", "in-flight value", y_out, e);
    chk("R11", "done after drain", done, 1);
    ym[1] = e;
    adc_v[0] = 16'sd5000;
    servo_pass();
    chk("R12", "no strobe when disabled", y_strobe, 0);
    chk("R12", "done stays", done, 1);
    adc_v[0] = 16'sd2000;
    servo_en = 1'b1;
    servo_pass();
    e = exp_y(0, 65536, 65536, 0, bx0[0], bx1[0], ym[1]);
    chk("R12", "x history not advanced", y_out, e);
    ym[1] = e;
  endtask

  initial begin
    rst_n = 1'b0; servo_en = 0; cycle_tick = 0; ctrl_we = 0; cfg_we = 0; y_we = 0;
    rd_state = 0; ctrl_word = '0; cfg_profile = '0; cfg_word = '0; cfg_data = '0;
    rd_profile = '0; rd_word = '0;
    for (int i = 0; i < 8; i++) begin adc_v[i] = '0; bx0[i] = 0; bx1[i] = 0; end
    for (int i = 0; i < 32; i++) ym[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_ctrl();
    t_basic();
    t_recur();
    t_sat();
    t_adc();
    t_iir_off();
    t_hold();
    t_ywr();
    t_disable();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R4 watchdog: actual=hung expected=complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule